// File: doc/BRIEF.md
# Shadow Register Reload and Interrupt Unit

This block keeps two copies of a small bank of display configuration words. Software writes the shadow copy through a single-cycle register port. The active copy drives the display pipeline, and it changes only when a reload is requested. A reload is either applied on the next clock, or held until the next vertical-blanking strobe. If the display is switched off, a held reload does not wait for a blanking strobe that will never come, so disabling layers still takes effect.

The same block collects four event sources into one interrupt line: a line event, a FIFO underrun, a bus transfer error and the completion of a reload. Each source has an enable bit, a sticky status flag and a write-one-to-clear bit. All three registers use the same bit order.

Register words, by address: 0 is control, with display enable at bit 0. Address 1 is the reload request. Address 2 is interrupt enable, address 3 is interrupt status and address 4 is interrupt clear. Addresses 8 onward hold the shadow configuration words.

Top module: `cfg_reload_irq`

## Requirements
- R1: After reset, all active words are 0, interrupt status, enable and the reload request read as 0, the display enable is 0 and the interrupt line is low.
- R2: A write to a shadow word (address 8+i) reads back at once but leaves the active words unchanged until a reload copies them.
- R3: Writing 1 to bit 0 of the reload request register (address 1) makes bit 0 read back as 1 for one cycle. On the next clock edge, every active word takes its shadow value and the bit clears itself.
- R4: Writing 1 to bit 1 of the reload request register, while the display is enabled, holds the request (bit 1 reads 1) and the active words unchanged until a clock edge at which the vertical-blanking strobe is high. At that edge the copy is made and the bit clears.
- R5: While display enable (address 0, bit 0) is 0, a pending vertical-blanking reload is applied at the next clock edge without a blanking strobe.
- R6: The reload-done status flag (bit 3) is set at the same edge where a reload copies the shadow words and its request bit clears.
- R7: A pulse on the line event, FIFO underrun or transfer error input sets status bit 0, 1 or 2 respectively, whatever the enable bits hold.
- R8: Writing to the clear register (address 4) clears exactly the status flags whose bit is 1 in the written value. Writing back a value just read from status clears all flags that were read.
- R9: If an event and a clear of the same flag occur in the same cycle, the flag remains set.
- R10: The interrupt line is high exactly when some status flag is set together with its enable bit (address 2).
- R11: The clear register and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | ADDR_W (4) | Register word address |
| reg_wdata_i | input | DATA_W (32) | Write data |
| reg_rdata_o | output | DATA_W (32) | Read data for reg_addr_i, combinational |
| vblank_i | input | 1 | Start of vertical blanking strobe |
| line_evt_i | input | 1 | Line event pulse |
| fifo_urun_i | input | 1 | FIFO underrun pulse |
| xfer_err_i | input | 1 | Bus transfer error pulse |
| cfg_active_o | output | NUM_CFG*CFG_W (128) | Active configuration words, word i at bits i*CFG_W |
| disp_en_o | output | 1 | Display enable from control bit 0 |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The copy is tried in three ways, and comparing them separates the trigger conditions. An immediate request must land on the very next edge. A deferred request must survive several idle cycles with the display on and land only on the blanking edge. A deferred request with the display off must land without any strobe. The interrupt side is driven with single events, with several events together and with partial clears. Writing back the read status value is checked separately. A clear that collides with an event shows whether set or clear has priority. An event whose source is not enabled shows whether status and enable are kept apart.

// File: rtl/cfg_reload_pkg.sv
package cfg_reload_pkg;
    localparam int ADR_CTRL   = 0;
    localparam int ADR_RELOAD = 1;
    localparam int ADR_IEN    = 2;
    localparam int ADR_ISTAT  = 3;
    localparam int ADR_ICLR   = 4;
    localparam int ADR_CFG0   = 8;

    localparam int NUM_SRC    = 4;
    localparam int SRC_LINE   = 0;
    localparam int SRC_URUN   = 1;
    localparam int SRC_XERR   = 2;
    localparam int SRC_RELOAD = 3;

    localparam int REQ_IMM    = 0;
    localparam int REQ_VBL    = 1;
endpackage

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank #(
    parameter int NUM_CFG = 4,
    parameter int CFG_W   = 32,
    parameter int ADDR_W  = 4,
    parameter int BASE    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [CFG_W-1:0]         wdata_i,
    input  logic                     load_i,
    output logic [NUM_CFG*CFG_W-1:0] shadow_o,
    output logic [NUM_CFG*CFG_W-1:0] active_o
);
    typedef struct packed {
        logic [CFG_W-1:0] shadow;
        logic [CFG_W-1:0] active;
    } slot_t;

    for (genvar i = 0; i < NUM_CFG; i++) begin : g_slot
        slot_t slot_d, slot_q;
        logic  hit;

        assign hit = wr_i && (addr_i == ADDR_W'(BASE + i));

        always_comb begin
            slot_d = slot_q;
            // the copy takes the value held before this edge's write
            if (load_i) slot_d.active = slot_q.shadow;
            if (hit)    slot_d.shadow = wdata_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign shadow_o[i*CFG_W +: CFG_W] = slot_q.shadow;
        assign active_o[i*CFG_W +: CFG_W] = slot_q.active;
    end
endmodule

// File: rtl/cfg_reload_ctrl.sv
module cfg_reload_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_wr_i,
    input  logic [1:0] req_wdata_i,
    input  logic       disp_en_i,
    input  logic       vblank_i,
    output logic [1:0] req_o,
    output logic       fire_o
);
    import cfg_reload_pkg::*;

    typedef struct packed {
        logic vbl;
        logic imm;
    } req_t;

    req_t req_d, req_q;
    logic vbl_go;

    // a deferred request also goes when the display is off: no strobe follows
    assign vbl_go = req_q.vbl && (vblank_i || !disp_en_i);
    assign fire_o = req_q.imm || vbl_go;

    always_comb begin
        req_d = req_q;
        if (fire_o) begin
            req_d.imm = 1'b0;
            req_d.vbl = 1'b0;
        end
        if (req_wr_i) begin
            req_d.imm = req_d.imm | req_wdata_i[REQ_IMM];
            req_d.vbl = req_d.vbl | req_wdata_i[REQ_VBL];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign req_o = {req_q.vbl, req_q.imm};
endmodule

// File: rtl/cfg_irq_ctrl.sv
module cfg_irq_ctrl #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_wr_i,
    input  logic            clr_wr_i,
    input  logic [NSRC-1:0] wdata_i,
    input  logic [NSRC-1:0] evt_i,
    output logic [NSRC-1:0] en_o,
    output logic [NSRC-1:0] stat_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] stat;
    } irq_t;

    irq_t st_d, st_q;
    logic [NSRC-1:0] clr_mask;

    assign clr_mask = clr_wr_i ? wdata_i : '0;

    always_comb begin
        st_d = st_q;
        if (en_wr_i) st_d.en = wdata_i;
        // set after clear: an event in the clearing cycle survives
        st_d.stat = (st_q.stat & ~clr_mask) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign stat_o = st_q.stat;
    assign irq_o  = |(st_q.stat & st_q.en);
endmodule

// File: rtl/cfg_reload_irq.sv
module cfg_reload_irq #(
    parameter int NUM_CFG = 4,
    parameter int CFG_W   = 32,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr_i,
    input  logic [ADDR_W-1:0]        reg_addr_i,
    input  logic [DATA_W-1:0]        reg_wdata_i,
    output logic [DATA_W-1:0]        reg_rdata_o,
    input  logic                     vblank_i,
    input  logic                     line_evt_i,
    input  logic                     fifo_urun_i,
    input  logic                     xfer_err_i,
    output logic [NUM_CFG*CFG_W-1:0] cfg_active_o,
    output logic                     disp_en_o,
    output logic                     irq_o
);
    import cfg_reload_pkg::*;

    localparam int FLAT_W = NUM_CFG * CFG_W;

    typedef struct packed {
        logic disp_en;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic               wr_ctrl, wr_reload, wr_ien, wr_iclr;
    logic [1:0]         req;
    logic               fire;
    logic [NUM_SRC-1:0] ien, status, events;
    logic [FLAT_W-1:0]  shadow_flat;

    assign wr_ctrl   = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_CTRL));
    assign wr_reload = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_RELOAD));
    assign wr_ien    = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_IEN));
    assign wr_iclr   = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_ICLR));

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) ctrl_d.disp_en = reg_wdata_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign disp_en_o = ctrl_q.disp_en;

    cfg_reload_ctrl u_reload (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_wr_i   (wr_reload),
        .req_wdata_i(reg_wdata_i[1:0]),
        .disp_en_i  (ctrl_q.disp_en),
        .vblank_i   (vblank_i),
        .req_o      (req),
        .fire_o     (fire)
    );

    cfg_shadow_bank #(
        .NUM_CFG(NUM_CFG),
        .CFG_W  (CFG_W),
        .ADDR_W (ADDR_W),
        .BASE   (ADR_CFG0)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i[CFG_W-1:0]),
        .load_i  (fire),
        .shadow_o(shadow_flat),
        .active_o(cfg_active_o)
    );

    always_comb begin
        events             = '0;
        events[SRC_LINE]   = line_evt_i;
        events[SRC_URUN]   = fifo_urun_i;
        events[SRC_XERR]   = xfer_err_i;
        events[SRC_RELOAD] = fire;
    end

    cfg_irq_ctrl #(.NSRC(NUM_SRC)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr_i (wr_ien),
        .clr_wr_i(wr_iclr),
        .wdata_i (reg_wdata_i[NUM_SRC-1:0]),
        .evt_i   (events),
        .en_o    (ien),
        .stat_o  (status),
        .irq_o   (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(ADR_CTRL))   reg_rdata_o = DATA_W'(ctrl_q.disp_en);
        if (reg_addr_i == ADDR_W'(ADR_RELOAD)) reg_rdata_o = DATA_W'(req);
        if (reg_addr_i == ADDR_W'(ADR_IEN))    reg_rdata_o = DATA_W'(ien);
        if (reg_addr_i == ADDR_W'(ADR_ISTAT))  reg_rdata_o = DATA_W'(status);
        for (int i = 0; i < NUM_CFG; i++) begin
            if (reg_addr_i == ADDR_W'(ADR_CFG0 + i))
                reg_rdata_o = DATA_W'(shadow_flat[i*CFG_W +: CFG_W]);
        end
    end
endmodule

// File: rtl/cfg_reload_irq_chk.sv
module cfg_reload_irq_chk #(
    parameter int NUM_CFG = 4,
    parameter int CFG_W   = 32,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr_i,
    input logic [ADDR_W-1:0]        reg_addr_i,
    input logic [DATA_W-1:0]        reg_wdata_i,
    input logic                     line_evt_i,
    input logic                     fifo_urun_i,
    input logic [NUM_CFG*CFG_W-1:0] cfg_active_o,
    input logic [NUM_CFG*CFG_W-1:0] shadow_flat,
    input logic                     fire,
    input logic [1:0]               req,
    input logic [3:0]               status,
    input logic                     disp_en_o
);
    // R2
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(cfg_active_o));

    // R3
    copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cfg_active_o == $past(shadow_flat));

    // R6
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !(reg_wr_i && reg_addr_i == ADDR_W'(1))) |=> (status[3] && req == 2'b00));

    // R5
    off_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req[1] && !disp_en_o) |=> !req[1] || $past(reg_wr_i));

    // R7
    line_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_evt_i |=> status[0]);

    // R8
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == ADDR_W'(4) && reg_wdata_i[1] && !fifo_urun_i) |=> !status[1]);
endmodule

bind cfg_reload_irq cfg_reload_irq_chk #(
    .NUM_CFG(NUM_CFG),
    .CFG_W  (CFG_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .line_evt_i  (line_evt_i),
    .fifo_urun_i (fifo_urun_i),
    .cfg_active_o(cfg_active_o),
    .shadow_flat (shadow_flat),
    .fire        (fire),
    .req         (req),
    .status      (status),
    .disp_en_o   (disp_en_o)
);

// File: tb/cfg_reload_irq_bench.sv
module cfg_reload_irq_bench;
    localparam int NUM_CFG = 4;
    localparam int CFG_W   = 32;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     reg_wr_i = 1'b0;
    logic [3:0]               reg_addr_i = '0;
    logic [31:0]              reg_wdata_i = '0;
    logic [31:0]              reg_rdata_o;
    logic                     vblank_i = 1'b0;
    logic                     line_evt_i = 1'b0;
    logic                     fifo_urun_i = 1'b0;
    logic                     xfer_err_i = 1'b0;
    logic [NUM_CFG*CFG_W-1:0] cfg_active_o;
    logic                     disp_en_o;
    logic                     irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [CFG_W-1:0] sh [NUM_CFG];
    logic [CFG_W-1:0] act [NUM_CFG];

    always #2.5 clk = ~clk;

    cfg_reload_irq u_cfg_reload_irq (.*);

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [3:0] a, logic [31:0] exp);
        reg_addr_i = a;
        #0.5;
        check(tag, reg_rdata_o, exp);
    endtask

    task automatic act_chk(string tag);
        for (int i = 0; i < NUM_CFG; i++)
            check(tag, cfg_active_o[i*CFG_W +: CFG_W], act[i]);
    endtask

    task automatic pulse(logic [2:0] m);
        @(negedge clk);
        line_evt_i = m[0]; fifo_urun_i = m[1]; xfer_err_i = m[2];
        @(negedge clk);
        line_evt_i = 0; fifo_urun_i = 0; xfer_err_i = 0;
    endtask

    task automatic load_shadows(logic [31:0] seed);
        for (int i = 0; i < NUM_CFG; i++) begin
            sh[i] = seed ^ (32'h0101_0101 * (i + 1));
            wr(4'(8 + i), sh[i]);
        end
    endtask

    task automatic t_reset;
        act_chk("R1 active");
        check("R1 irq", 32'(irq_o), 0);
        check("R1 disp", 32'(disp_en_o), 0);
        rd_chk("R1 reload", 4'd1, 0);
        rd_chk("R1 status", 4'd3, 0);
        rd_chk("R1 enable", 4'd2, 0);
    endtask

    task automatic t_shadow_hold;
        load_shadows(32'hA5A5_0000);
        for (int i = 0; i < NUM_CFG; i++) rd_chk("R2 readback", 4'(8 + i), sh[i]);
        act_chk("R2 active held");
    endtask

    task automatic t_imm;
        wr(4'd1, 32'h1);
        rd_chk("R3 request pending", 4'd1, 32'h1);
        act_chk("R3 not yet");
        rd_chk("R6 no flag yet", 4'd3, 0);
        @(negedge clk);
        for (int i = 0; i < NUM_CFG; i++) act[i] = sh[i];
        act_chk("R3 copied");
        rd_chk("R3 self clear", 4'd1, 0);
        rd_chk("R6 done flag", 4'd3, 32'h8);
    endtask

    task automatic t_events;
        wr(4'd4, 32'hF);
        rd_chk("R8 clear all", 4'd3, 0);
        pulse(3'b001);
        rd_chk("R7 line", 4'd3, 32'h1);
        pulse(3'b110);
        rd_chk("R7 urun xerr", 4'd3, 32'h7);
        check("R10 none enabled", 32'(irq_o), 0);
        wr(4'd4, 32'h2);
        rd_chk("R8 partial", 4'd3, 32'h5);
        rd_chk("R8 read value", 4'd3, 32'h5);
        wr(4'd4, reg_rdata_o);
        rd_chk("R8 write back", 4'd3, 0);
    endtask

    task automatic t_collide;
        @(negedge clk);
        line_evt_i = 1; reg_wr_i = 1; reg_addr_i = 4'd4; reg_wdata_i = 32'h1;
        @(negedge clk);
        line_evt_i = 0; reg_wr_i = 0;
        rd_chk("R9 event wins", 4'd3, 32'h1);
        wr(4'd4, 32'h1);
        rd_chk("R9 later clear", 4'd3, 0);
    endtask

    task automatic t_vbl;
        wr(4'd0, 32'h1);
        check("R4 disp on", 32'(disp_en_o), 1);
        load_shadows(32'h0F0F_1234);
        wr(4'd1, 32'h2);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            rd_chk("R4 pending", 4'd1, 32'h2);
            act_chk("R4 held");
        end
        rd_chk("R6 no flag", 4'd3, 0);
        @(negedge clk); vblank_i = 1;
        @(negedge clk); vblank_i = 0;
        for (int i = 0; i < NUM_CFG; i++) act[i] = sh[i];
        act_chk("R4 copied at blank");
        rd_chk("R4 cleared", 4'd1, 0);
        rd_chk("R6 flag", 4'd3, 32'h8);
        wr(4'd4, 32'h8);
    endtask

    task automatic t_off;
        load_shadows(32'h5555_AAAA);
        wr(4'd0, 32'h0);
        wr(4'd1, 32'h2);
        rd_chk("R5 pending", 4'd1, 32'h2);
        act_chk("R5 not yet");
        @(negedge clk);
        for (int i = 0; i < NUM_CFG; i++) act[i] = sh[i];
        act_chk("R5 copied without blank");
        rd_chk("R5 cleared", 4'd1, 0);
    endtask

    task automatic t_irq;
        wr(4'd4, 32'hF);
        wr(4'd2, 32'h1);
        rd_chk("R10 enable readback", 4'd2, 32'h1);
        pulse(3'b010);
        check("R10 masked source", 32'(irq_o), 0);
        pulse(3'b001);
        check("R10 enabled source", 32'(irq_o), 1);
        wr(4'd4, 32'h1);
        check("R10 after clear", 32'(irq_o), 0);
        wr(4'd2, 32'h2);
        check("R10 enable later", 32'(irq_o), 1);
    endtask

    task automatic t_unmapped;
        rd_chk("R11 clear reads 0", 4'd4, 0);
        rd_chk("R11 addr 5", 4'd5, 0);
        rd_chk("R11 addr 15", 4'd15, 0);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < NUM_CFG; i++) begin sh[i] = '0; act[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shadow_hold();
        t_imm();
        t_events();
        t_collide();
        t_vbl();
        t_off();
        t_irq();
        t_unmapped();
        done = 1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end
endmodule